// File: doc/BRIEF.md
# Programmable Address Window Decoder with Remap

This block checks each outbound 32-bit request address against a small set of programmable windows. Every window is described by three registers: a base, an inclusive top, and a remap value. All three work in 64 KB units. When the upper half of the request falls inside an enabled window, the block reports four things: a hit, the index of the window, the translated address, and whether the data path should byte-swap for this access. Window 0 is the I/O window. Windows 1 to 4 are memory windows.

Software programs the windows through a simple configuration port. A write is strobed by `cfg_wr_en`. A read returns the addressed register on `cfg_rd_data` within the same cycle. The decode result is registered: the outputs describe the request address that was present at the previous rising clock edge.

Top module: `addr_window_decoder`

## Requirements
- R1: With default parameters there are five windows. Index 0 is the I/O window and indices 1 to 4 are memory windows. The configuration address is `{window[2:0], sel[1:0]}`, where sel 0 selects the base register, sel 1 the top register and sel 2 the remap register.
- R2: After reset every base register reads 0x00000FFF, every top and remap register reads 0, and no request hits.
- R3: A read returns all 32 bits exactly as they were last written. Writes to sel 3, or to a window index of 5 or above, change nothing, and reads at those addresses return 0.
- R4: A window hits when its base field (bits [15:0]) is at or below request bits [31:16], and request bits [31:16] are at or below its top field (bits [15:0]).
- R5: A window whose top field is less than or equal to its base field is disabled and never hits.
- R6: On a hit, the translated address bits [31:16] equal remap[15:0] + (request[31:16] - base[15:0]), modulo 2^16. Bits [15:0] equal request[15:0].
- R7: On a hit, `swap_en` is 1 unless bit 24 of the winning window's base register is 1. A 1 in that bit selects no swap.
- R8: When several enabled windows hit, the lowest window index wins.
- R9: On a miss, `hit`, `win_idx`, `xlat_addr` and `swap_en` are all 0.
- R10: The outputs reflect `req_addr` as sampled at the previous rising edge. A register write takes effect for the decode at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address {window, sel} |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_rd_data | output | 32 | Contents of the addressed register (combinational) |
| req_addr | input | 32 | Outbound request address |
| hit | output | 1 | Request fell in an enabled window |
| win_idx | output | 3 | Index of the winning window |
| xlat_addr | output | 32 | Translated address |
| swap_en | output | 1 | Byte-swap enable for the access |

## Verification
The readback assertion assumes that `cfg_addr` is held steady from a write into the next cycle. The bench therefore drives each write and the read that follows it on the same address. The low-half pass-through assertion assumes that `req_addr` changes only away from the clock edge, so the bench changes it only at falling edges. No assertion assumes anything about how windows are programmed: the stimulus deliberately builds closed, equal-bound, overlapping and wrapping windows, and the bench compares every output against its own model of these rules.

// File: rtl/awd_pkg.sv
package awd_pkg;
   // Register selector inside one window's slot of the configuration map.
   typedef enum logic [1:0] {
      SEL_BASE  = 2'd0,
      SEL_TOP   = 2'd1,
      SEL_REMAP = 2'd2,
      SEL_RSVD  = 2'd3
   } awd_sel_e;

   localparam int unsigned SEL_W = 2;
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
   import awd_pkg::*;
#(
   parameter int unsigned NUM_WIN    = 5,
   parameter int unsigned REG_W      = 32,
   parameter int unsigned HI_W       = 16,
   parameter int unsigned IDX_W      = 3,
   parameter int unsigned CFG_AW     = 5,
   parameter int unsigned NOSWAP_BIT = 24,
   parameter logic [REG_W-1:0] CLOSED_BASE = 'h0FFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   output logic [HI_W-1:0]   base_f  [NUM_WIN],
   output logic [HI_W-1:0]   top_f   [NUM_WIN],
   output logic [HI_W-1:0]   remap_f [NUM_WIN],
   output logic [NUM_WIN-1:0] noswap
);
   logic [IDX_W-1:0] win;
   awd_sel_e         sel;
   logic [REG_W-1:0] base_q  [NUM_WIN];
   logic [REG_W-1:0] top_q   [NUM_WIN];
   logic [REG_W-1:0] remap_q [NUM_WIN];

   assign win = cfg_addr[CFG_AW-1:SEL_W];
   assign sel = awd_sel_e'(cfg_addr[SEL_W-1:0]);

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[w]  <= CLOSED_BASE;
            top_q[w]   <= '0;
            remap_q[w] <= '0;
         end else if (wr_en && win == IDX_W'(w)) begin
            case (sel)
               SEL_BASE:  base_q[w]  <= wr_data;
               SEL_TOP:   top_q[w]   <= wr_data;
               SEL_REMAP: remap_q[w] <= wr_data;
               default:   ;
            endcase
         end
      end
      assign base_f[w]  = base_q[w][HI_W-1:0];
      assign top_f[w]   = top_q[w][HI_W-1:0];
      assign remap_f[w] = remap_q[w][HI_W-1:0];
      assign noswap[w]  = base_q[w][NOSWAP_BIT];
   end

   always_comb begin
      rd_data = '0;
      for (int w = 0; w < NUM_WIN; w++) begin
         if (win == IDX_W'(w)) begin
            case (sel)
               SEL_BASE:  rd_data = base_q[w];
               SEL_TOP:   rd_data = top_q[w];
               SEL_REMAP: rd_data = remap_q[w];
               default:   rd_data = '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/awd_match.sv
module awd_match #(
   parameter int unsigned HI_W = 16
) (
   input  logic [HI_W-1:0] base_i,
   input  logic [HI_W-1:0] top_i,
   input  logic [HI_W-1:0] remap_i,
   input  logic            noswap_i,
   input  logic [HI_W-1:0] req_hi_i,
   output logic            hit_o,
   output logic [HI_W-1:0] xlat_hi_o,
   output logic            swap_o
);
   logic enabled;

   assign enabled   = top_i > base_i;
   assign hit_o     = enabled && (req_hi_i >= base_i) && (req_hi_i <= top_i);
   assign xlat_hi_o = remap_i + (req_hi_i - base_i);
   assign swap_o    = ~noswap_i;
endmodule

// File: rtl/awd_select.sv
module awd_select #(
   parameter int unsigned NUM_WIN      = 5,
   parameter int unsigned HI_W         = 16,
   parameter int unsigned GRAN_W       = 16,
   parameter int unsigned IDX_W        = 3,
   parameter bit          REGISTER_OUT = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_WIN-1:0]     hit_vec,
   input  logic [HI_W-1:0]        xlat_hi [NUM_WIN],
   input  logic [NUM_WIN-1:0]     swap_vec,
   input  logic [GRAN_W-1:0]      req_lo,
   output logic                   hit_o,
   output logic [IDX_W-1:0]       idx_o,
   output logic [HI_W+GRAN_W-1:0] addr_o,
   output logic                   swap_o
);
   logic                   hit_d;
   logic [IDX_W-1:0]       idx_d;
   logic [HI_W+GRAN_W-1:0] addr_d;
   logic                   swap_d;

   // Scan from the top so the lowest hitting index is assigned last.
   always_comb begin
      hit_d  = 1'b0;
      idx_d  = '0;
      addr_d = '0;
      swap_d = 1'b0;
      for (int w = NUM_WIN - 1; w >= 0; w--) begin
         if (hit_vec[w]) begin
            hit_d  = 1'b1;
            idx_d  = IDX_W'(w);
            addr_d = {xlat_hi[w], req_lo};
            swap_d = swap_vec[w];
         end
      end
   end

   if (REGISTER_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hit_o  <= 1'b0;
            idx_o  <= '0;
            addr_o <= '0;
            swap_o <= 1'b0;
         end else begin
            hit_o  <= hit_d;
            idx_o  <= idx_d;
            addr_o <= addr_d;
            swap_o <= swap_d;
         end
      end
   end else begin : g_comb
      assign hit_o  = hit_d;
      assign idx_o  = idx_d;
      assign addr_o = addr_d;
      assign swap_o = swap_d;
   end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
   import awd_pkg::*;
#(
   parameter int unsigned NUM_WIN      = 5,
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned GRAN_W       = 16,
   parameter int unsigned REG_W        = 32,
   parameter int unsigned NOSWAP_BIT   = 24,
   parameter bit          REGISTER_OUT = 1'b1,
   parameter logic [REG_W-1:0] CLOSED_BASE = 'h0FFF,
   localparam int unsigned HI_W   = ADDR_W - GRAN_W,
   localparam int unsigned IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
   localparam int unsigned CFG_AW = IDX_W + SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [REG_W-1:0]  cfg_wr_data,
   output logic [REG_W-1:0]  cfg_rd_data,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              hit,
   output logic [IDX_W-1:0]  win_idx,
   output logic [ADDR_W-1:0] xlat_addr,
   output logic              swap_en
);
   if (NUM_WIN < 1) begin : g_bad_num
      $error("NUM_WIN must be at least 1");
   end
   if (GRAN_W < 1 || GRAN_W >= ADDR_W) begin : g_bad_gran
      $error("GRAN_W must lie between 1 and ADDR_W-1");
   end
   if (REG_W < HI_W) begin : g_bad_regw
      $error("REG_W must hold a full window field");
   end
   if (NOSWAP_BIT >= REG_W || NOSWAP_BIT < HI_W) begin : g_bad_swap
      $error("NOSWAP_BIT must sit above the address field inside REG_W");
   end

   logic [HI_W-1:0]    base_f  [NUM_WIN];
   logic [HI_W-1:0]    top_f   [NUM_WIN];
   logic [HI_W-1:0]    remap_f [NUM_WIN];
   logic [HI_W-1:0]    xlat_hi [NUM_WIN];
   logic [NUM_WIN-1:0] noswap;
   logic [NUM_WIN-1:0] hit_vec;
   logic [NUM_WIN-1:0] swap_vec;

   awd_regfile #(
      .NUM_WIN(NUM_WIN), .REG_W(REG_W), .HI_W(HI_W), .IDX_W(IDX_W),
      .CFG_AW(CFG_AW), .NOSWAP_BIT(NOSWAP_BIT), .CLOSED_BASE(CLOSED_BASE)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
      .wr_data(cfg_wr_data), .rd_data(cfg_rd_data),
      .base_f(base_f), .top_f(top_f), .remap_f(remap_f), .noswap(noswap)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
      awd_match #(.HI_W(HI_W)) match_i (
         .base_i(base_f[w]), .top_i(top_f[w]), .remap_i(remap_f[w]),
         .noswap_i(noswap[w]), .req_hi_i(req_addr[ADDR_W-1:GRAN_W]),
         .hit_o(hit_vec[w]), .xlat_hi_o(xlat_hi[w]), .swap_o(swap_vec[w])
      );
   end

   awd_select #(
      .NUM_WIN(NUM_WIN), .HI_W(HI_W), .GRAN_W(GRAN_W), .IDX_W(IDX_W),
      .REGISTER_OUT(REGISTER_OUT)
   ) sel_i (
      .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec), .xlat_hi(xlat_hi),
      .swap_vec(swap_vec), .req_lo(req_addr[GRAN_W-1:0]),
      .hit_o(hit), .idx_o(win_idx), .addr_o(xlat_addr), .swap_o(swap_en)
   );
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
   parameter int unsigned NUM_WIN      = 5,
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned GRAN_W       = 16,
   parameter int unsigned REG_W        = 32,
   parameter int unsigned IDX_W        = 3,
   parameter int unsigned CFG_AW       = 5,
   parameter bit          REGISTER_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr_en,
   input logic [CFG_AW-1:0] cfg_addr,
   input logic [REG_W-1:0]  cfg_wr_data,
   input logic [REG_W-1:0]  cfg_rd_data,
   input logic [GRAN_W-1:0] req_lo,
   input logic              hit,
   input logic [IDX_W-1:0]  win_idx,
   input logic [ADDR_W-1:0] xlat_addr,
   input logic              swap_en
);
   logic cfg_ok;
   assign cfg_ok = ({1'b0, cfg_addr[CFG_AW-1:2]} < (IDX_W+1)'(NUM_WIN))
                   && (cfg_addr[1:0] != 2'd3);

   // R9: a miss leaves every other output at zero
   assert_miss_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (win_idx == '0 && xlat_addr == '0 && !swap_en));

   // R1: a reported index names an existing window
   assert_idx_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ({1'b0, win_idx} < (IDX_W+1)'(NUM_WIN)));

   // R3: a write to a real register reads back unchanged next cycle
   assert_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cfg_wr_en) && $past(cfg_ok) && cfg_addr == $past(cfg_addr))
      |-> cfg_rd_data == $past(cfg_wr_data));

   // R3: holes in the map read as zero
   assert_hole_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ok |-> cfg_rd_data == '0);

   // R6: the low half of the address passes through untranslated
   if (REGISTER_OUT) begin : g_reg
      assert_low_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && hit) |-> xlat_addr[GRAN_W-1:0] == $past(req_lo));
   end else begin : g_comb
      assert_low_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
         hit |-> xlat_addr[GRAN_W-1:0] == req_lo);
   end
endmodule

bind addr_window_decoder awd_checker #(
   .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .GRAN_W(GRAN_W), .REG_W(REG_W),
   .IDX_W(IDX_W), .CFG_AW(CFG_AW), .REGISTER_OUT(REGISTER_OUT)
) chk_i (
   .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
   .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
   .req_lo(req_addr[GRAN_W-1:0]), .hit(hit), .win_idx(win_idx),
   .xlat_addr(xlat_addr), .swap_en(swap_en)
);

// File: tb/addr_window_decoder_tb_top.sv
`timescale 1ns/1ps
module addr_window_decoder_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [31:0] cfg_wr_data = '0;
   logic [31:0] cfg_rd_data;
   logic [31:0] req_addr = '0;
   logic        hit;
   logic [2:0]  win_idx;
   logic [31:0] xlat_addr;
   logic        swap_en;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // bench model of the register contents
   logic [31:0] m_base [5];
   logic [31:0] m_top  [5];
   logic [31:0] m_rmp  [5];

   always #2 clk = ~clk;

   addr_window_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
      .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
      .req_addr(req_addr), .hit(hit), .win_idx(win_idx),
      .xlat_addr(xlat_addr), .swap_en(swap_en)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   function automatic logic [4:0] ra(int w, int s);
      return {3'(w), 2'(s)};
   endfunction

   task automatic cfg_write(int w, int s, logic [31:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_addr = ra(w, s); cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      if (w < 5) begin
         if (s == 0) m_base[w] = d;
         else if (s == 1) m_top[w] = d;
         else if (s == 2) m_rmp[w] = d;
      end
   endtask

   task automatic cfg_read(string tag, int w, int s, logic [31:0] exp);
      @(negedge clk);
      cfg_addr = ra(w, s);
      #1;
      check(tag, cfg_rd_data, exp);
   endtask

   // expected decode computed from the requirements R4..R9
   task automatic model(input logic [31:0] a, output logic h, output logic [2:0] i,
                        output logic [31:0] x, output logic s);
      h = 1'b0; i = '0; x = '0; s = 1'b0;
      for (int w = 0; w < 5; w++) begin
         if (!h && m_top[w][15:0] > m_base[w][15:0] &&
             a[31:16] >= m_base[w][15:0] && a[31:16] <= m_top[w][15:0]) begin
            h = 1'b1;
            i = 3'(w);
            x = {16'(m_rmp[w][15:0] + (a[31:16] - m_base[w][15:0])), a[15:0]};
            s = ~m_base[w][24];
         end
      end
   endtask

   task automatic probe(string tag, logic [31:0] a);
      logic eh; logic [2:0] ei; logic [31:0] ex; logic es;
      model(a, eh, ei, ex, es);
      @(negedge clk);
      req_addr = a;
      @(negedge clk);
      check({tag, " hit"},  32'(hit),     32'(eh));
      check({tag, " idx"},  32'(win_idx), 32'(ei));
      check({tag, " xlat"}, xlat_addr,    ex);
      check({tag, " swap"}, 32'(swap_en), 32'(es));
   endtask

   task automatic t_reset();
      for (int w = 0; w < 5; w++) begin
         cfg_read("R2 base reset", w, 0, 32'h0000_0FFF);
         cfg_read("R2 top reset", w, 1, 32'h0);
         cfg_read("R2 remap reset", w, 2, 32'h0);
      end
      probe("R2 closed after reset", 32'h0000_1234);
      probe("R2 closed after reset hi", 32'h0FFF_0000);
   endtask

   task automatic t_readback();
      cfg_write(2, 0, 32'hDEAD_0010);
      cfg_read("R3 base readback", 2, 0, 32'hDEAD_0010);
      cfg_write(2, 1, 32'hA5A5_5A5A);
      cfg_read("R3 top readback", 2, 1, 32'hA5A5_5A5A);
      cfg_write(2, 2, 32'h1234_8765);
      cfg_read("R3 remap readback", 2, 2, 32'h1234_8765);
      // restore window 2 to closed
      cfg_write(2, 0, 32'h0000_0FFF);
      cfg_write(2, 1, 32'h0);
      cfg_write(2, 2, 32'h0);
   endtask

   task automatic t_holes();
      cfg_write(1, 3, 32'hFFFF_FFFF);
      cfg_read("R3 sel3 reads zero", 1, 3, 32'h0);
      cfg_write(5, 0, 32'h0000_0001);
      cfg_write(6, 1, 32'h0000_FFFF);
      cfg_write(7, 2, 32'h0000_1111);
      cfg_read("R3 win5 reads zero", 5, 0, 32'h0);
      cfg_read("R3 win7 reads zero", 7, 2, 32'h0);
      cfg_read("R3 win1 base untouched", 1, 0, 32'h0000_0FFF);
      cfg_read("R3 win1 top untouched", 1, 1, 32'h0);
      cfg_read("R3 win4 remap untouched", 4, 2, 32'h0);
      probe("R3 hole writes open nothing", 32'h0001_0000);
   endtask

   task automatic t_basic();
      cfg_write(1, 0, 32'h0000_0100);
      cfg_write(1, 1, 32'h0000_01FF);
      cfg_write(1, 2, 32'h0000_8000);
      probe("R4 inside at base", 32'h0100_ABCD);
      probe("R4 inside at top", 32'h01FF_0001);
      probe("R6 mid offset", 32'h0142_7777);
      probe("R4 just above top", 32'h0200_0000);
      probe("R4 just below base", 32'h00FF_FFFF);
      probe("R1 window 1 memory index", 32'h0150_0000);
   endtask

   task automatic t_disabled();
      cfg_write(3, 0, 32'h0000_0500);
      cfg_write(3, 1, 32'h0000_0500);
      probe("R5 top equals base", 32'h0500_0000);
      cfg_write(3, 1, 32'h0000_0400);
      probe("R5 top below base", 32'h0450_0000);
      probe("R5 top below base at base", 32'h0500_0010);
   endtask

   task automatic t_swap();
      cfg_write(1, 0, 32'h0100_0100);
      probe("R7 no-swap bit set", 32'h0120_0000);
      cfg_read("R7 swap bit reads back", 1, 0, 32'h0100_0100);
      cfg_write(1, 0, 32'hFEFF_0100);
      probe("R7 other high bits ignored", 32'h0120_0000);
      cfg_write(1, 0, 32'h0000_0100);
      probe("R7 swap restored", 32'h0120_0000);
   endtask

   task automatic t_overlap();
      cfg_write(0, 0, 32'h0000_0180);
      cfg_write(0, 1, 32'h0000_0190);
      cfg_write(0, 2, 32'h0000_0001);
      probe("R8 io window wins overlap", 32'h0185_0000);
      probe("R8 outside io falls to mem", 32'h0191_0000);
      cfg_write(4, 0, 32'h0000_0100);
      cfg_write(4, 1, 32'h0000_0FFF);
      cfg_write(4, 2, 32'h0000_4000);
      probe("R8 window 1 beats window 4", 32'h01A0_0000);
      probe("R8 only window 4", 32'h0800_0042);
   endtask

   task automatic t_wrap();
      cfg_write(4, 0, 32'h0000_0F00);
      cfg_write(4, 1, 32'h0000_FFFF);
      cfg_write(4, 2, 32'h0000_FFF0);
      probe("R6 remap wraps", 32'h0F20_5555);
      probe("R6 top of space", 32'hFFFF_FFFF);
   endtask

   task automatic t_timing();
      // R10: outputs follow the address of the previous edge, not the current one
      @(negedge clk);
      req_addr = 32'h0100_0000;
      @(negedge clk);
      req_addr = 32'h0000_0000;
      #0.5;
      check("R10 output holds previous request", 32'(hit), 32'd1);
      @(negedge clk);
      check("R10 output follows new request", 32'(hit), 32'd0);
      // a write shows up in the decode of the next edge
      cfg_write(1, 1, 32'h0000_0100);
      probe("R10 write closes window", 32'h0100_0000);
   endtask

   initial begin
      for (int w = 0; w < 5; w++) begin
         m_base[w] = 32'h0000_0FFF; m_top[w] = '0; m_rmp[w] = '0;
      end
      repeat (3) @(negedge clk);
      check("R2 hit low in reset", 32'(hit), 32'd0);
      rst_n = 1'b1;
      t_reset();
      t_readback();
      t_holes();
      t_basic();
      t_disabled();
      t_swap();
      t_overlap();
      t_wrap();
      t_timing();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule